// File: doc/BRIEF.md
# Receive Buffer Descriptor Manager

This block sits between an Ethernet receive path and system memory. It keeps a ring of receive buffer descriptors in memory and places each incoming frame into the buffers those descriptors point to. On the first byte of a frame it reads the descriptor at its queue pointer. If software has released that buffer, the block writes the frame bytes through a simple bus-master port. It then writes a status word and hands the buffer back to software by setting the ownership bit.

Bytes arrive one per `rxValid` strobe and the source cannot be stalled. A small byte FIFO absorbs bus latency. If that FIFO overflows because a grant came too late, or the bus answers with an error, the rest of the frame is dropped. The buffer in progress is then kept for the next frame. If the block meets a descriptor that software still owns, it drops the frame, pulses an interrupt and counts a resource error.

The bus port holds `memReq` and the transfer fields steady until `memGnt`. The transfer completes in the cycle of the grant, and read data and `memErr` are valid in that cycle. The source leaves a few idle cycles between frames.

Top module: `rx_desc_mgr`

## Requirements
- R1: After reset `memReq`, all three interrupt outputs and `resErrCnt` are zero, and the first frame uses the descriptor at parameter `QUEUE_BASE`.
- R2: A descriptor is two little-endian 32-bit words at the queue pointer. Word 0 holds the buffer address in bits 31:2, a wrap flag in bit 1 and ownership in bit 0 (1 = owned by software). On the first byte of a frame, word 0 is read at the queue pointer.
- R3: When word 0 has bit 0 clear, the stored frame bytes are written in arrival order, one byte write each, to consecutive addresses starting at the buffer address.
- R4: When a buffer is closed, word 1 (pointer + 4) is written with the stored frame length so far in bits 11:0. Bit 14 is set in the first buffer of a frame and bit 15 in the buffer holding its last stored byte. Then word 0 is rewritten with bit 0 set. A frame of exactly 128 stored bytes uses one buffer with both flags set.
- R5: Buffers hold 128 bytes, and a longer frame continues in the next descriptor. The pointer moves on by 8 bytes after each closed buffer, or back to `QUEUE_BASE` when the closed descriptor had its wrap flag set.
- R6: If word 0 is read with bit 0 set, nothing is written to that buffer or descriptor. `bufUnavailIrq` pulses, `resErrCnt` increments, the frame is discarded and the pointer stays on that descriptor.
- R7: If a descriptor owned by software is met part-way through a frame, the buffers already filled stay handed over, with bit 14 set and bit 15 clear, which marks a fragment. Otherwise the frame is handled as in R6.
- R8: A FIFO overflow or a bus error response raises `overrunIrq`, and the remainder of the frame is discarded. The buffer in progress gets no status and no ownership write, and the next frame reuses that descriptor.
- R9: With `cfgStripFcs` high at frame start, the last four bytes of the frame are not written and the length is reduced by four (floored at zero).
- R10: `frameDoneIrq` pulses once for each frame whose last buffer was handed over, and never for a discarded frame.
- R11: Each interrupt output is a single-cycle pulse, and at most one of them is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgStripFcs | input | 1 | Drop the four trailing check bytes of each frame |
| rxValid | input | 1 | One received byte is present |
| rxData | input | 8 | Received byte |
| rxLast | input | 1 | Marks the final byte of a frame |
| memReq | output | 1 | Bus transfer request |
| memWe | output | 1 | Transfer is a write |
| memByte | output | 1 | Write is one byte (low 8 bits of data) rather than a word |
| memAddr | output | ADDR_W | Byte address |
| memWdata | output | 32 | Write data |
| memRdata | input | 32 | Read data, valid with the grant |
| memGnt | input | 1 | Transfer accepted and completed this cycle |
| memErr | input | 1 | Error response with the grant |
| bufUnavailIrq | output | 1 | Pulse: descriptor still owned by software |
| overrunIrq | output | 1 | Pulse: receive overrun |
| frameDoneIrq | output | 1 | Pulse: frame handed to software |
| resErrCnt | output | CNT_W | Count of frames dropped for lack of a buffer |

## Verification
Frames of 60, 20, 300 and exactly 128 bytes show whether the split into buffers, the placement of the flags and the wrap back to the ring base are right. Short and medium frames with FCS stripping test the length reduction, including the case where nothing is left to store. An owned descriptor at frame start is contrasted with one met mid-frame, which must leave a fragment behind. A stalled grant is contrasted with an error response; in both cases the next frame must land in the same descriptor.

// File: rtl/rxdm_pkg.sv
package rxdm_pkg;
  localparam int OWN_BIT  = 0;
  localparam int WRAP_BIT = 1;
  localparam int SOF_BIT  = 14;
  localparam int EOF_BIT  = 15;

  typedef enum logic [1:0] {
    OP_DESC_RD,
    OP_BYTE_WR,
    OP_STAT_WR,
    OP_ADDR_WR
  } busOpT;

  typedef enum logic [2:0] {
    S_IDLE,
    S_FETCH,
    S_FILL,
    S_STAT,
    S_OWN,
    S_DROP
  } ctrlStateT;

  typedef struct packed {
    logic  startFrame;
    logic  acceptBytes;
    logic  latchDesc;
    logic  popByte;
    logic  advance;
    logic  flush;
    logic  incResErr;
    busOpT op;
  } ctrlStrobesT;
endpackage

// File: rtl/rxdm_byte_fifo.sv
module rxdm_byte_fifo #(
  parameter int DEPTH = 8,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int FC_W  = $clog2(DEPTH + 1)
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            push,
  input  logic            pop,
  input  logic            flush,
  input  logic [7:0]      din,
  output logic [7:0]      dout,
  output logic [FC_W-1:0] count
);
  logic [7:0]       store [DEPTH];
  logic [PTR_W-1:0] wrPtr, rdPtr;

  function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (push) store[wrPtr] <= din;
  end

  always_ff @(posedge clk) begin
    if (!rstN || flush) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (push) wrPtr <= bump(wrPtr);
      if (pop)  rdPtr <= bump(rdPtr);
      count <= count + FC_W'(push) - FC_W'(pop);
    end
  end

  assign dout = store[rdPtr];

  assert_fifo_no_overfill_R8: assert property (@(posedge clk) disable iff (!rstN)
    push |-> (count < FC_W'(DEPTH)));
  assert_fifo_no_underflow_R3: assert property (@(posedge clk) disable iff (!rstN)
    pop |-> (count != '0));
endmodule

// File: rtl/rxdm_datapath.sv
module rxdm_datapath
  import rxdm_pkg::*;
#(
  parameter int          ADDR_W     = 32,
  parameter int          LEN_W      = 12,
  parameter int          BUF_BYTES  = 128,
  parameter int          FIFO_DEPTH = 8,
  parameter int          CNT_W      = 16,
  parameter logic [31:0] QUEUE_BASE = 32'h0000_0100
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobesT       stb,
  input  logic              rxValid,
  input  logic [7:0]        rxData,
  input  logic              rxLast,
  input  logic              cfgStripFcs,
  input  logic [31:0]       memRdata,
  output logic [ADDR_W-1:0] memAddr,
  output logic [31:0]       memWdata,
  output logic              memWe,
  output logic              memByte,
  output logic              descOwned,
  output logic              fifoHasData,
  output logic              frameEnd,
  output logic              bufFull,
  output logic              lastSeen,
  output logic              overflowSeen,
  output logic [CNT_W-1:0]  resErrCnt
);
  localparam int DESC_BYTES = 8;
  localparam int FCS_BYTES  = 4;
  localparam int OFF_W      = $clog2(BUF_BYTES) + 1;
  localparam int FC_W       = $clog2(FIFO_DEPTH + 1);

  logic [ADDR_W-1:0] descPtr;
  logic [31:0]       descWord;
  logic [OFF_W-1:0]  offset;
  logic [LEN_W-1:0]  frameLen;
  logic              sofFlag, stripLat;
  logic [FC_W-1:0]   fifoCount, keepCount;
  logic [7:0]        fifoDout;
  logic              fifoFull, fifoPush;
  logic [31:0]       statusWord;

  assign fifoFull = (fifoCount == FC_W'(FIFO_DEPTH));
  assign fifoPush = rxValid && stb.acceptBytes && !fifoFull;

  rxdm_byte_fifo #(.DEPTH(FIFO_DEPTH)) byteFifo (
    .clk   (clk),
    .rstN  (rstN),
    .push  (fifoPush),
    .pop   (stb.popByte),
    .flush (stb.flush),
    .din   (rxData),
    .dout  (fifoDout),
    .count (fifoCount)
  );

  assign keepCount   = stripLat ? FC_W'(FCS_BYTES) : '0;
  assign fifoHasData = fifoCount > keepCount;
  assign frameEnd    = lastSeen && (fifoCount <= keepCount);
  assign bufFull     = (offset == OFF_W'(BUF_BYTES));
  assign descOwned   = memRdata[OWN_BIT];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      descPtr      <= QUEUE_BASE[ADDR_W-1:0];
      descWord     <= '0;
      offset       <= '0;
      frameLen     <= '0;
      sofFlag      <= 1'b0;
      stripLat     <= 1'b0;
      lastSeen     <= 1'b0;
      overflowSeen <= 1'b0;
      resErrCnt    <= '0;
    end else begin
      if (stb.startFrame) begin
        frameLen <= '0;
        sofFlag  <= 1'b1;
        stripLat <= cfgStripFcs;
        lastSeen <= rxLast;
      end else if (rxValid && rxLast) begin
        lastSeen <= 1'b1;
      end
      if (stb.flush) overflowSeen <= 1'b0;
      else if (rxValid && stb.acceptBytes && fifoFull) overflowSeen <= 1'b1;
      if (stb.latchDesc) begin
        descWord <= memRdata;
        offset   <= '0;
      end
      if (stb.popByte) begin
        offset   <= offset + 1'b1;
        frameLen <= frameLen + 1'b1;
      end
      if (stb.advance) begin
        descPtr <= descWord[WRAP_BIT] ? QUEUE_BASE[ADDR_W-1:0]
                                      : descPtr + ADDR_W'(DESC_BYTES);
        sofFlag <= 1'b0;
      end
      if (stb.incResErr) resErrCnt <= resErrCnt + 1'b1;
    end
  end

  always_comb begin
    statusWord = '0;
    statusWord[LEN_W-1:0] = frameLen;
    statusWord[SOF_BIT]   = sofFlag;
    statusWord[EOF_BIT]   = frameEnd;
  end

  always_comb begin
    memWe    = (stb.op != OP_DESC_RD);
    memByte  = (stb.op == OP_BYTE_WR);
    memAddr  = descPtr;
    memWdata = '0;
    case (stb.op)
      OP_BYTE_WR: begin
        memAddr  = {descWord[ADDR_W-1:2], 2'b00} + ADDR_W'(offset);
        memWdata = {24'h0, fifoDout};
      end
      OP_STAT_WR: begin
        memAddr  = descPtr + ADDR_W'(4);
        memWdata = statusWord;
      end
      OP_ADDR_WR: memWdata = descWord | 32'h1;
      default: ;
    endcase
  end

  assert_buffer_bound_R5: assert property (@(posedge clk) disable iff (!rstN)
    stb.popByte |-> (offset < OFF_W'(BUF_BYTES)));
  assert_ptr_step_R5: assert property (@(posedge clk) disable iff (!rstN)
    (descPtr != $past(descPtr)) |->
      ((descPtr == QUEUE_BASE[ADDR_W-1:0]) || (descPtr == $past(descPtr) + ADDR_W'(DESC_BYTES))));
  assert_reserr_step_R6: assert property (@(posedge clk) disable iff (!rstN)
    (resErrCnt != $past(resErrCnt)) |-> $past(stb.incResErr));
endmodule

// File: rtl/rxdm_ctrl.sv
module rxdm_ctrl
  import rxdm_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        rxValid,
  input  logic        memGnt,
  input  logic        memErr,
  input  logic        descOwned,
  input  logic        fifoHasData,
  input  logic        frameEnd,
  input  logic        bufFull,
  input  logic        lastSeen,
  input  logic        overflowSeen,
  output logic        memReq,
  output ctrlStrobesT stb,
  output logic        overrunIrq,
  output logic        bufUnavailIrq,
  output logic        frameDoneIrq
);
  ctrlStateT state, nextState;
  logic goOverrun, goUnavail, goDone;

  always_comb begin
    stb       = '0;
    stb.op    = OP_DESC_RD;
    memReq    = 1'b0;
    nextState = state;
    goOverrun = 1'b0;
    goUnavail = 1'b0;
    goDone    = 1'b0;
    case (state)
      S_IDLE: begin
        stb.acceptBytes = 1'b1;
        if (rxValid) begin
          stb.startFrame = 1'b1;
          nextState      = S_FETCH;
        end
      end
      S_FETCH: begin
        stb.acceptBytes = 1'b1;
        if (overflowSeen) goOverrun = 1'b1;
        else begin
          memReq = 1'b1;
          if (memGnt) begin
            if (memErr)         goOverrun = 1'b1;
            else if (descOwned) goUnavail = 1'b1;
            else begin
              stb.latchDesc = 1'b1;
              nextState     = S_FILL;
            end
          end
        end
      end
      S_FILL: begin
        stb.acceptBytes = 1'b1;
        if (overflowSeen) goOverrun = 1'b1;
        else if (bufFull || frameEnd) nextState = S_STAT;
        else if (fifoHasData) begin
          memReq = 1'b1;
          stb.op = OP_BYTE_WR;
          if (memGnt) begin
            if (memErr) goOverrun = 1'b1;
            else        stb.popByte = 1'b1;
          end
        end
      end
      S_STAT: begin
        stb.acceptBytes = 1'b1;
        if (overflowSeen) goOverrun = 1'b1;
        else begin
          memReq = 1'b1;
          stb.op = OP_STAT_WR;
          if (memGnt) begin
            if (memErr) goOverrun = 1'b1;
            else        nextState = S_OWN;
          end
        end
      end
      S_OWN: begin
        stb.acceptBytes = 1'b1;
        if (overflowSeen) goOverrun = 1'b1;
        else begin
          memReq = 1'b1;
          stb.op = OP_ADDR_WR;
          if (memGnt) begin
            if (memErr) goOverrun = 1'b1;
            else begin
              stb.advance = 1'b1;
              if (frameEnd) begin
                goDone    = 1'b1;
                stb.flush = 1'b1;
                nextState = S_IDLE;
              end else begin
                nextState = S_FETCH;
              end
            end
          end
        end
      end
      S_DROP: begin
        if (lastSeen) nextState = S_IDLE;
      end
      default: nextState = S_IDLE;
    endcase
    if (goOverrun || goUnavail) begin
      stb.flush = 1'b1;
      nextState = S_DROP;
    end
    stb.incResErr = goUnavail;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state         <= S_IDLE;
      overrunIrq    <= 1'b0;
      bufUnavailIrq <= 1'b0;
      frameDoneIrq  <= 1'b0;
    end else begin
      state         <= nextState;
      overrunIrq    <= goOverrun;
      bufUnavailIrq <= goUnavail;
      frameDoneIrq  <= goDone;
    end
  end

  assert_irq_exclusive_R11: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({overrunIrq, bufUnavailIrq, frameDoneIrq}));
  assert_irq_pulse_R11: assert property (@(posedge clk) disable iff (!rstN)
    (overrunIrq || bufUnavailIrq || frameDoneIrq) |=> !(overrunIrq || bufUnavailIrq || frameDoneIrq));
  assert_unavail_quiet_R6: assert property (@(posedge clk) disable iff (!rstN)
    bufUnavailIrq |-> !memReq);
  assert_overrun_quiet_R8: assert property (@(posedge clk) disable iff (!rstN)
    overrunIrq |-> !memReq);
  assert_done_idle_R10: assert property (@(posedge clk) disable iff (!rstN)
    frameDoneIrq |-> !memReq);
  assert_req_held_R3: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && !memGnt) |=> (memReq || overflowSeen));
endmodule

// File: rtl/rx_desc_mgr.sv
module rx_desc_mgr
  import rxdm_pkg::*;
#(
  parameter int          ADDR_W     = 32,
  parameter int          LEN_W      = 12,
  parameter int          BUF_BYTES  = 128,
  parameter int          FIFO_DEPTH = 8,
  parameter int          CNT_W      = 16,
  parameter logic [31:0] QUEUE_BASE = 32'h0000_0100
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgStripFcs,
  input  logic              rxValid,
  input  logic [7:0]        rxData,
  input  logic              rxLast,
  output logic              memReq,
  output logic              memWe,
  output logic              memByte,
  output logic [ADDR_W-1:0] memAddr,
  output logic [31:0]       memWdata,
  input  logic [31:0]       memRdata,
  input  logic              memGnt,
  input  logic              memErr,
  output logic              bufUnavailIrq,
  output logic              overrunIrq,
  output logic              frameDoneIrq,
  output logic [CNT_W-1:0]  resErrCnt
);
  ctrlStrobesT stb;
  logic descOwned, fifoHasData, frameEnd, bufFull, lastSeen, overflowSeen;

  rxdm_ctrl ctrl (
    .clk           (clk),
    .rstN          (rstN),
    .rxValid       (rxValid),
    .memGnt        (memGnt),
    .memErr        (memErr),
    .descOwned     (descOwned),
    .fifoHasData   (fifoHasData),
    .frameEnd      (frameEnd),
    .bufFull       (bufFull),
    .lastSeen      (lastSeen),
    .overflowSeen  (overflowSeen),
    .memReq        (memReq),
    .stb           (stb),
    .overrunIrq    (overrunIrq),
    .bufUnavailIrq (bufUnavailIrq),
    .frameDoneIrq  (frameDoneIrq)
  );

  rxdm_datapath #(
    .ADDR_W     (ADDR_W),
    .LEN_W      (LEN_W),
    .BUF_BYTES  (BUF_BYTES),
    .FIFO_DEPTH (FIFO_DEPTH),
    .CNT_W      (CNT_W),
    .QUEUE_BASE (QUEUE_BASE)
  ) dpath (
    .clk          (clk),
    .rstN         (rstN),
    .stb          (stb),
    .rxValid      (rxValid),
    .rxData       (rxData),
    .rxLast       (rxLast),
    .cfgStripFcs  (cfgStripFcs),
    .memRdata     (memRdata),
    .memAddr      (memAddr),
    .memWdata     (memWdata),
    .memWe        (memWe),
    .memByte      (memByte),
    .descOwned    (descOwned),
    .fifoHasData  (fifoHasData),
    .frameEnd     (frameEnd),
    .bufFull      (bufFull),
    .lastSeen     (lastSeen),
    .overflowSeen (overflowSeen),
    .resErrCnt    (resErrCnt)
  );
endmodule

// File: tb/rx_desc_mgr_test.sv
module rx_desc_mgr_test;
  localparam int BASE   = 'h100;
  localparam int BUFB   = 'h200;
  localparam int MARKER = 32'h0000_7777;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cfgStripFcs = 1'b0;
  logic        rxValid = 1'b0;
  logic [7:0]  rxData = '0;
  logic        rxLast = 1'b0;
  logic        memReq, memWe, memByte;
  logic [31:0] memAddr, memWdata, memRdata;
  logic        memGnt, memErr;
  logic        bufUnavailIrq, overrunIrq, frameDoneIrq;
  logic [15:0] resErrCnt;

  logic        gntEn = 1'b1;
  logic        errOnByte = 1'b0;
  logic [7:0]  mem [0:4095];

  int checks = 0, errors = 0;
  int bnaTotal = 0, ovrTotal = 0, doneTotal = 0;
  int modelIdx = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  rx_desc_mgr uut (
    .clk(clk), .rstN(rstN), .cfgStripFcs(cfgStripFcs),
    .rxValid(rxValid), .rxData(rxData), .rxLast(rxLast),
    .memReq(memReq), .memWe(memWe), .memByte(memByte), .memAddr(memAddr),
    .memWdata(memWdata), .memRdata(memRdata), .memGnt(memGnt), .memErr(memErr),
    .bufUnavailIrq(bufUnavailIrq), .overrunIrq(overrunIrq),
    .frameDoneIrq(frameDoneIrq), .resErrCnt(resErrCnt)
  );

  int wordIdx;
  always_comb begin
    wordIdx  = int'(memAddr[11:2]) * 4;
    memGnt   = memReq && gntEn;
    memErr   = memGnt && errOnByte && memByte;
    memRdata = {mem[wordIdx+3], mem[wordIdx+2], mem[wordIdx+1], mem[wordIdx]};
  end

  always @(posedge clk) begin
    if (memGnt && memWe && !memErr) begin
      if (memByte) mem[int'(memAddr[11:0])] <= memWdata[7:0];
      else begin
        mem[wordIdx]   <= memWdata[7:0];
        mem[wordIdx+1] <= memWdata[15:8];
        mem[wordIdx+2] <= memWdata[23:16];
        mem[wordIdx+3] <= memWdata[31:24];
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  // Per-clock: counter and unavailable pulses seen at the ports agree (R6)
  always @(negedge clk) begin
    if (rstN) begin
      bnaTotal  += int'(bufUnavailIrq);
      ovrTotal  += int'(overrunIrq);
      doneTotal += int'(frameDoneIrq);
      chk(resErrCnt == bnaTotal[15:0], "R6 counter vs pulses", 32'(resErrCnt), 32'(bnaTotal));
      chk(int'(bufUnavailIrq) + int'(overrunIrq) + int'(frameDoneIrq) <= 1,
          "R11 one interrupt per cycle", {bufUnavailIrq, overrunIrq, frameDoneIrq}, 0);
    end
  end

  function automatic logic [31:0] rd32(input int a);
    return {mem[a+3], mem[a+2], mem[a+1], mem[a]};
  endfunction

  task automatic wr32(input int a, input logic [31:0] v);
    mem[a] = v[7:0]; mem[a+1] = v[15:8]; mem[a+2] = v[23:16]; mem[a+3] = v[31:24];
  endtask

  function automatic logic [31:0] descInit(input int idx);
    return 32'(BUFB + idx * 128) | ((idx == 3) ? 32'h2 : 32'h0);
  endfunction

  function automatic logic [7:0] pat(input int seed, input int i);
    return 8'((seed * 37 + i * 5 + 1) & 255);
  endfunction

  task automatic prepRing();
    for (int d = 0; d < 4; d++) begin
      wr32(BASE + 8 * d, descInit(d));
      wr32(BASE + 8 * d + 4, MARKER);
      for (int b = 0; b < 128; b++) mem[BUFB + d * 128 + b] = 8'hA5;
    end
  endtask

  task automatic sendFrame(input int len, input int seed);
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      rxValid = 1'b1; rxData = pat(seed, i); rxLast = (i == len - 1);
      @(negedge clk);
      rxValid = 1'b0; rxLast = 1'b0;
      repeat (1) @(negedge clk);
    end
    repeat (40) @(negedge clk);
  endtask

  // Expected placement of a completed frame starting at modelIdx
  task automatic checkFrame(input int len, input bit strip, input int seed, input string tag);
    int stored, nbuf, idx, lenHere, bad;
    logic [31:0] expStat;
    stored = strip ? ((len > 4) ? len - 4 : 0) : len;
    nbuf = (stored == 0) ? 1 : (stored + 127) / 128;
    for (int b = 0; b < nbuf; b++) begin
      idx = (modelIdx + b) % 4;
      lenHere = (stored < (b + 1) * 128) ? stored : (b + 1) * 128;
      expStat = 32'(lenHere) | ((b == 0) ? 32'h4000 : 0) | ((b == nbuf - 1) ? 32'h8000 : 0);
      chk(rd32(BASE + 8 * idx) == (descInit(idx) | 1), {tag, " owner word"}, rd32(BASE + 8 * idx), descInit(idx) | 1);
      chk(rd32(BASE + 8 * idx + 4) == expStat, {tag, " status"}, rd32(BASE + 8 * idx + 4), expStat);
      bad = -1;
      for (int k = b * 128; k < lenHere; k++)
        if (bad < 0 && mem[BUFB + idx * 128 + (k - b * 128)] != pat(seed, k)) bad = k;
      chk(bad < 0, {tag, " data bytes"}, bad, -1);
    end
    modelIdx = (modelIdx + nbuf) % 4;
  endtask

  task automatic checkUntouched(input int idx, input string tag);
    chk(rd32(BASE + 8 * idx) == descInit(idx) || rd32(BASE + 8 * idx) == (descInit(idx) | 1),
        {tag, " word0 kept"}, rd32(BASE + 8 * idx), descInit(idx));
    chk(rd32(BASE + 8 * idx + 4) == MARKER, {tag, " status kept"}, rd32(BASE + 8 * idx + 4), MARKER);
    chk(mem[BUFB + idx * 128] == 8'hA5, {tag, " buffer kept"}, mem[BUFB + idx * 128], 8'hA5);
  endtask

  initial begin
    int d0, b0, o0, r0;
    for (int i = 0; i < 4096; i++) mem[i] = 8'h00;
    prepRing();
    repeat (3) @(negedge clk);
    chk(!memReq && !bufUnavailIrq && !overrunIrq && !frameDoneIrq, "R1 outputs in reset",
        {memReq, bufUnavailIrq, overrunIrq, frameDoneIrq}, 0);
    rstN = 1'b1;
    @(negedge clk);
    chk(resErrCnt == 0 && !memReq, "R1 after reset", 32'(resErrCnt), 0);

    // R2 R3 R4 R10: single-buffer frame at the ring base
    d0 = doneTotal;
    sendFrame(60, 1);
    checkFrame(60, 0, 1, "R2 R3 R4 60B");
    chk(doneTotal - d0 == 1, "R10 done pulse", doneTotal - d0, 1);
    // R5: three buffers, the last one wraps
    prepRing(); sendFrame(300, 2); checkFrame(300, 0, 2, "R5 300B");
    prepRing(); sendFrame(20, 3);
    chk(modelIdx == 0, "R5 model at base", modelIdx, 0);
    checkFrame(20, 0, 3, "R5 after wrap");
    // R9: stripping
    prepRing(); cfgStripFcs = 1'b1; sendFrame(70, 4); checkFrame(70, 1, 4, "R9 70B strip");
    prepRing(); sendFrame(3, 5); checkFrame(3, 1, 5, "R9 3B strip");
    cfgStripFcs = 1'b0;
    // R4 boundary: exactly one full buffer
    prepRing(); sendFrame(128, 6); checkFrame(128, 0, 6, "R4 128B");

    // R6: owned descriptor at frame start
    prepRing(); wr32(BASE + 8 * modelIdx, descInit(modelIdx) | 1);
    b0 = bnaTotal; d0 = doneTotal; r0 = int'(resErrCnt);
    sendFrame(50, 7);
    chk(bnaTotal - b0 == 1, "R6 unavailable pulse", bnaTotal - b0, 1);
    chk(doneTotal == d0, "R10 no done on drop", doneTotal - d0, 0);
    chk(int'(resErrCnt) == r0 + 1, "R6 resource count", 32'(resErrCnt), r0 + 1);
    checkUntouched(modelIdx, "R6");
    prepRing(); sendFrame(10, 8); checkFrame(10, 0, 8, "R6 pointer kept");

    // R7: owned descriptor mid-frame leaves a fragment
    prepRing(); wr32(BASE + 8 * ((modelIdx + 1) % 4), descInit((modelIdx + 1) % 4) | 1);
    b0 = bnaTotal;
    sendFrame(200, 9);
    chk(rd32(BASE + 8 * modelIdx + 4) == 32'h0000_4080, "R7 fragment status",
        rd32(BASE + 8 * modelIdx + 4), 32'h0000_4080);
    chk(rd32(BASE + 8 * modelIdx) == (descInit(modelIdx) | 1), "R7 fragment owned",
        rd32(BASE + 8 * modelIdx), descInit(modelIdx) | 1);
    chk(bnaTotal - b0 == 1, "R7 unavailable pulse", bnaTotal - b0, 1);
    modelIdx = (modelIdx + 1) % 4;
    checkUntouched(modelIdx, "R7 owned desc");
    prepRing(); sendFrame(5, 10); checkFrame(5, 0, 10, "R7 next frame");

    // R8: late grant overflows the FIFO
    prepRing(); gntEn = 1'b0; o0 = ovrTotal; d0 = doneTotal;
    sendFrame(40, 11);
    gntEn = 1'b1; repeat (5) @(negedge clk);
    chk(ovrTotal - o0 == 1, "R8 overrun pulse late grant", ovrTotal - o0, 1);
    chk(doneTotal == d0, "R10 no done on overrun", doneTotal - d0, 0);
    checkUntouched(modelIdx, "R8 late grant");
    chk(rd32(BASE + 8 * modelIdx) == descInit(modelIdx), "R8 not handed", rd32(BASE + 8 * modelIdx), descInit(modelIdx));
    prepRing(); sendFrame(30, 12); checkFrame(30, 0, 12, "R8 reuse after late grant");

    // R8: bus error on a data write
    prepRing(); errOnByte = 1'b1; o0 = ovrTotal;
    sendFrame(30, 13);
    errOnByte = 1'b0;
    chk(ovrTotal - o0 == 1, "R8 overrun pulse bus error", ovrTotal - o0, 1);
    checkUntouched(modelIdx, "R8 bus error");
    chk(rd32(BASE + 8 * modelIdx) == descInit(modelIdx), "R8 error not handed", rd32(BASE + 8 * modelIdx), descInit(modelIdx));
    prepRing(); sendFrame(12, 14); checkFrame(12, 0, 14, "R8 reuse after error");

    if (!finished) begin
      finished = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++; errors++;
      $display("FAIL watchdog actual %0d expected %0d", 1, 0);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule